// File: doc/BRIEF.md
# Divider Phase Alignment Controller

A divide-by-four clock divider comes out of reset in one of four phases relative to a system reference, and which one is a matter of chance. This controller makes that phase repeatable. It pulses the divider reset, lets the divider settle for a fixed number of reference events, and then samples the divider's two-bit count on the next reference event to learn which quarter-cycle phase it landed in.

The controller has two modes, picked when a run starts. A calibration run resets the divider once and keeps the measured phase as the target phase. An alignment run resets the divider over and over until the measured phase equals the target phase. It reports done when the phases match, or raises an error after a fixed number of failed attempts. The target phase can also be written from outside while the controller is idle, so a value kept from an earlier calibration can be restored.

Top module: `phase_align_ctrl`

## Requirements
- R1: During and right after reset, divReset, done, error and busy are low and storedPhase is 00.
- R2: The divider count encodes the phase as 00=0°, 01=90°, 10=180° and 11=270°. A calibration run (calMode=1 when startReq is accepted) gives exactly one reset pulse, copies the measured count into storedPhase, and ends with done high.
- R3: Every divider reset pulse holds divReset high for exactly 4 clock cycles.
- R4: After divReset falls, the first 8 refStrobe events are ignored, and the phase is sampled from divCount on the 9th.
- R5: In an alignment run (calMode=0), a measured phase that differs from storedPhase starts a new reset pulse. A matching phase ends the run with done high and storedPhase unchanged.
- R6: When 64 attempts have all failed, error goes high, done stays low, and no more reset pulses are issued. A match on the 64th attempt still ends with done.
- R7: done and error hold their values while idle, until a new startReq is accepted. Both are low in the cycle after that acceptance.
- R8: phaseLoad while idle writes phaseIn into storedPhase. When phaseLoad and startReq come in the same idle cycle, the run that starts uses the newly loaded phase. phaseLoad while busy has no effect.
- R9: startReq while a run is in progress is ignored, and the run continues with its pulse count unchanged.
- R10: busy and divReset go high in the cycle after startReq is accepted. busy stays high until the final measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a run (accepted only when idle) |
| calMode | input | 1 | 1 = calibration run, 0 = alignment run; sampled at start |
| refStrobe | input | 1 | System phase reference event, one cycle wide |
| divCount | input | 2 | Divider state, read as the phase |
| phaseLoad | input | 1 | Write phaseIn into the stored phase (idle only) |
| phaseIn | input | 2 | External stored-phase value |
| divReset | output | 1 | Reset to the divider |
| storedPhase | output | 2 | Target phase register |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished with the phase aligned or recorded |
| error | output | 1 | Alignment gave up after the retry limit |

## Verification
Two functions can land in the same cycle: an external phase load and the acceptance of a start. The bench provokes this by raising phaseLoad and startReq together on an idle controller. The divider model then shows only the newly loaded phase, so the run ends in done after one pulse only if the load took effect before the first comparison. A second timing case is the measurement strobe itself. The divider model presents the matching phase only while the 9th post-reset strobe is pending, so sampling one strobe early or late cannot produce done.

// File: rtl/phase_align_pkg.sv
package phase_align_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PULSE   = 2'd1,
    ST_SETTLE  = 2'd2,
    ST_MEASURE = 2'd3
  } alignState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCyc;
    logic incCyc;
    logic clrStrb;
    logic incStrb;
    logic clrTry;
    logic incTry;
    logic storeCal;
    logic loadExt;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic cycLast;
    logic settleLast;
    logic phaseMatch;
    logic triesLast;
  } dpSts_t;

endpackage

// File: rtl/phase_align_dp.sv
module phase_align_dp
  import phase_align_pkg::*;
#(
  parameter int PHASE_W        = 2,
  parameter int RST_CYCLES     = 4,
  parameter int SETTLE_STROBES = 8,
  parameter int MAX_TRIES      = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [PHASE_W-1:0] divCount,
  input  logic [PHASE_W-1:0] phaseIn,
  output dpSts_t             sts,
  output logic [PHASE_W-1:0] storedPhase
);

  localparam int CYC_W  = $clog2(RST_CYCLES + 1);
  localparam int STRB_W = $clog2(SETTLE_STROBES + 1);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);

  logic [CYC_W-1:0]  cycCnt;
  logic [STRB_W-1:0] strbCnt;
  logic [TRY_W-1:0]  tryCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (ctl.clrCyc) begin
      cycCnt <= '0;
    end else if (ctl.incCyc) begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strbCnt <= '0;
    end else if (ctl.clrStrb) begin
      strbCnt <= '0;
    end else if (ctl.incStrb) begin
      strbCnt <= strbCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tryCnt <= '0;
    end else if (ctl.clrTry) begin
      tryCnt <= '0;
    end else if (ctl.incTry) begin
      tryCnt <= tryCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedPhase <= '0;
    end else if (ctl.storeCal) begin
      storedPhase <= divCount;
    end else if (ctl.loadExt) begin
      storedPhase <= phaseIn;
    end
  end

  always_comb begin
    sts.cycLast    = (cycCnt == CYC_W'(RST_CYCLES - 1));
    sts.settleLast = (strbCnt == STRB_W'(SETTLE_STROBES - 1));
    sts.phaseMatch = (divCount == storedPhase);
    sts.triesLast  = (tryCnt == TRY_W'(MAX_TRIES - 1));
  end

  // R6
  try_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt <= TRY_W'(MAX_TRIES - 1));

  // R4
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strbCnt <= STRB_W'(SETTLE_STROBES));

  // R3
  cyc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycCnt <= CYC_W'(RST_CYCLES));

endmodule

// File: rtl/phase_align_fsm.sv
module phase_align_fsm
  import phase_align_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   calMode,
  input  logic   refStrobe,
  input  logic   phaseLoad,
  input  dpSts_t sts,
  output dpCtl_t ctl,
  output logic   divReset,
  output logic   busy,
  output logic   done,
  output logic   error
);

  alignState_t state, stateNext;
  logic calLat;
  logic setDone, setErr, startAcc;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    setDone   = 1'b0;
    setErr    = 1'b0;
    startAcc  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ctl.loadExt = phaseLoad;
        if (startReq) begin
          startAcc   = 1'b1;
          ctl.clrCyc = 1'b1;
          ctl.clrTry = 1'b1;
          stateNext  = ST_PULSE;
        end
      end
      ST_PULSE: begin
        ctl.incCyc = 1'b1;
        if (sts.cycLast) begin
          ctl.clrStrb = 1'b1;
          stateNext   = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (refStrobe) begin
          ctl.incStrb = 1'b1;
          if (sts.settleLast) stateNext = ST_MEASURE;
        end
      end
      ST_MEASURE: begin
        if (refStrobe) begin
          if (calLat) begin
            ctl.storeCal = 1'b1;
            setDone      = 1'b1;
            stateNext    = ST_IDLE;
          end else if (sts.phaseMatch) begin
            setDone   = 1'b1;
            stateNext = ST_IDLE;
          end else if (sts.triesLast) begin
            setErr    = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctl.incTry = 1'b1;
            ctl.clrCyc = 1'b1;
            stateNext  = ST_PULSE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      calLat <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      state <= stateNext;
      if (startAcc) begin
        calLat <= calMode;
        done   <= 1'b0;
        error  <= 1'b0;
      end else begin
        if (setDone) done  <= 1'b1;
        if (setErr)  error <= 1'b1;
      end
    end
  end

  assign divReset = (state == ST_PULSE);
  assign busy     = (state != ST_IDLE);

  // R6
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !divReset);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !busy && !startReq) |=> done);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

endmodule

// File: rtl/phase_align_ctrl.sv
module phase_align_ctrl
  import phase_align_pkg::*;
#(
  parameter int PHASE_W        = 2,
  parameter int RST_CYCLES     = 4,
  parameter int SETTLE_STROBES = 8,
  parameter int MAX_TRIES      = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               calMode,
  input  logic               refStrobe,
  input  logic [PHASE_W-1:0] divCount,
  input  logic               phaseLoad,
  input  logic [PHASE_W-1:0] phaseIn,
  output logic               divReset,
  output logic [PHASE_W-1:0] storedPhase,
  output logic               busy,
  output logic               done,
  output logic               error
);

  localparam int LEN_W = $clog2(RST_CYCLES + 1) + 1;

  dpCtl_t ctl;
  dpSts_t sts;

  phase_align_fsm i_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .calMode  (calMode),
    .refStrobe(refStrobe),
    .phaseLoad(phaseLoad),
    .sts      (sts),
    .ctl      (ctl),
    .divReset (divReset),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  phase_align_dp #(
    .PHASE_W       (PHASE_W),
    .RST_CYCLES    (RST_CYCLES),
    .SETTLE_STROBES(SETTLE_STROBES),
    .MAX_TRIES     (MAX_TRIES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .divCount   (divCount),
    .phaseIn    (phaseIn),
    .sts        (sts),
    .storedPhase(storedPhase)
  );

  // pulse length monitor for the checks below
  logic [LEN_W-1:0] pulseLen;
  always_ff @(posedge clk) begin
    if (!rstN) pulseLen <= '0;
    else if (divReset) pulseLen <= pulseLen + 1'b1;
    else pulseLen <= '0;
  end

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(divReset) |-> (pulseLen == LEN_W'(RST_CYCLES)));

  // R8
  ext_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && phaseLoad) |=> (storedPhase == $past(phaseIn)));

  // R8
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(done) && !$rose(done)) |-> $stable(storedPhase) || $rose(done));

endmodule

// File: tb/test_phase_align_ctrl.sv
module test_phase_align_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, calMode = 1'b0, refStrobe = 1'b0, phaseLoad = 1'b0;
  logic [1:0] divCount = 2'b00, phaseIn = 2'b00;
  logic divReset, busy, done, error;
  logic [1:0] storedPhase;

  always #4 clk = ~clk;  // 125 MHz

  phase_align_ctrl i_phase_align_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .calMode(calMode),
    .refStrobe(refStrobe), .divCount(divCount), .phaseLoad(phaseLoad),
    .phaseIn(phaseIn), .divReset(divReset), .storedPhase(storedPhase),
    .busy(busy), .done(done), .error(error)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // divider and reference model
  int attempt = 0, since = 0, hiLen = 0, minW = 1000, maxW = 0, phCnt = 0;
  bit prevRst = 0;
  bit winMode = 0;
  logic [1:0] goodPh = 2'b00;
  int nWrong = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevRst = 0; since = 0; hiLen = 0;
      refStrobe = 1'b0;
    end else begin
      if (divReset && !prevRst) attempt++;
      if (prevRst) since = 0;
      else if (refStrobe) since++;
      if (divReset) hiLen++;
      else if (prevRst) begin
        if (hiLen < minW) minW = hiLen;
        if (hiLen > maxW) maxW = hiLen;
        hiLen = 0;
      end
      prevRst = divReset;
      refStrobe = (phCnt == 3);
      phCnt = (phCnt + 1) % 4;
      if (winMode) divCount = (since == 8) ? goodPh : (goodPh ^ 2'b01);
      else divCount = (attempt - base <= nWrong) ? (goodPh ^ 2'b10) : goodPh;
    end
  end

  int base = 0;

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic waitIdle(input string req);
    int n = 0;
    while (busy && n < 6000) begin @(negedge clk); n++; end
    chk(!busy, req, n, 6000);
  endtask

  // vector: cal, win, preset, good, nWrong
  localparam logic [15:0] VEC [7] = '{
    {1'b1, 1'b0, 2'd0, 2'd2, 2'b0, 8'd0},
    {1'b0, 1'b0, 2'd2, 2'd2, 2'b0, 8'd0},
    {1'b0, 1'b0, 2'd1, 2'd1, 2'b0, 8'd3},
    {1'b0, 1'b0, 2'd3, 2'd3, 2'b0, 8'd63},
    {1'b0, 1'b0, 2'd0, 2'd0, 2'b0, 8'd64},
    {1'b1, 1'b0, 2'd1, 2'd3, 2'b0, 8'd0},
    {1'b0, 1'b1, 2'd2, 2'd2, 2'b0, 8'd0}
  };

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!divReset && !done && !error && !busy, "R1", {done, error, busy, divReset}, 0);
    chk(storedPhase == 2'b00, "R1", storedPhase, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!divReset && !busy && !done && !error, "R1", {done, error, busy, divReset}, 0);

    foreach (VEC[i]) begin
      automatic bit cal = VEC[i][15];
      automatic logic [1:0] pre = VEC[i][13:12];
      automatic logic [1:0] gd = VEC[i][11:10];
      automatic int nw = VEC[i][7:0];
      automatic int expP = cal ? 1 : ((nw + 1 > 64) ? 64 : nw + 1);
      automatic bit expE = !cal && nw >= 64;
      automatic logic [1:0] expS = cal ? gd : pre;
      phaseIn = pre; phaseLoad = 1'b1;
      @(negedge clk);
      phaseLoad = 1'b0;
      chk(storedPhase == pre, "R8", storedPhase, pre);
      winMode = VEC[i][14]; goodPh = gd; nWrong = nw; base = attempt;
      calMode = cal; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      chk(busy && divReset, "R10", {busy, divReset}, 3);
      chk(!done && !error, "R7", {done, error}, 0);
      waitIdle("R10");
      chk(attempt - base == expP, cal ? "R2" : (VEC[i][14] ? "R4" : (expE ? "R6" : "R5")), attempt - base, expP);
      chk(error == expE, "R6", error, expE);
      chk(done == !expE, cal ? "R2" : "R5", done, !expE);
      chk(storedPhase == expS, cal ? "R2" : "R5", storedPhase, expS);
      repeat (20) @(negedge clk);
      chk(done == !expE && error == expE && !divReset, "R7", {done, error}, {!expE, expE});
    end

    // R8 load and start in the same idle cycle
    winMode = 0; goodPh = 2'd3; nWrong = 0; base = attempt;
    phaseIn = 2'd3; phaseLoad = 1'b1; calMode = 1'b0; startReq = 1'b1;
    @(negedge clk);
    phaseLoad = 1'b0; startReq = 1'b0;
    waitIdle("R8");
    chk(done && storedPhase == 2'd3, "R8", storedPhase, 3);
    chk(attempt - base == 1, "R8", attempt - base, 1);

    // R9 start and R8 load while busy are ignored
    goodPh = 2'd3; nWrong = 5; base = attempt;
    calMode = 1'b0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (60) @(negedge clk);
    startReq = 1'b1; phaseIn = 2'd0; phaseLoad = 1'b1;
    @(negedge clk);
    startReq = 1'b0; phaseLoad = 1'b0;
    repeat (30) @(negedge clk);
    chk(storedPhase == 2'd3, "R8", storedPhase, 3);
    waitIdle("R9");
    chk(attempt - base == 6, "R9", attempt - base, 6);
    chk(done && !error, "R9", done, 1);

    // R3 pulse width over every pulse seen
    chk(minW == 4 && maxW == 4, "R3", maxW, 4);
    chk(minW == 4, "R3", minW, 4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule